// File: doc/BRIEF.md
# Four-Level Second-Stage Page Walker

This block turns a guest-physical address into a host-physical address. It walks a four-level table hierarchy that sits in memory. A 64-bit root pointer, presented with each request, packs four things: the frame number of the top-level table, the number of levels minus one, a memory-type code and an accessed/dirty enable. The block checks this pointer first. A malformed pointer is rejected at once, and nothing is read from memory.

A correct request starts a walk. The walk reads one 64-bit entry per level over a port that allows only one request in flight, and it checks the entry's read/write/execute bits against the requested access at every level. An entry with none of the three bits set counts as absent. An entry that lacks the requested right ends the walk with a violation that reports the level where it stopped. A walk that grants the access at all four levels returns the final frame joined with the page offset.

Top module: `s2w_walker`

## Requirements
- R1: After reset, and for as long as `req_valid` stays low, `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0. No memory read happens without an accepted request.
- R2: The first entry read is at address {root_ptr[47:12], 12'h000} + 8 × gpa[47:39].
- R3: The read at level n (n = 0 for the top table, up to 3) uses table base + 8 × gpa[47−9n : 39−9n]. The reads come strictly in the order level 0, 1, 2, 3.
- R4: For the levels below the top, the table base is bits 47:12 of the entry read at the level above.
- R5: A completed walk gives `rsp_status` = 0 (ok), `rsp_level` = 3 and `rsp_hpa` = {final entry bits 47:12, gpa[11:0]}.
- R6: Access codes are 0 read, 1 write and 2 execute. Entry bits 0, 1 and 2 grant read, write and execute. The first entry on the path that lacks the requested bit ends the walk with `rsp_status` = 1 (violation), `rsp_level` = that level, `rsp_hpa` = 0, and no further read.
- R7: An entry whose bits 2:0 are all zero is treated as absent. The walk ends with `rsp_status` = 1 at that level, and no deeper level is read.
- R8: If root_ptr[5:3] ≠ 3 or root_ptr[11:7] ≠ 0, the response carries `rsp_status` = 2 (configuration error), `rsp_level` = 0 and `rsp_hpa` = 0, and no memory read is issued.
- R9: Every response reports `rsp_memtype` = root_ptr[2:0] as it was when the request was accepted, for example 0 (uncached) or 6 (write-back).
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged. Only one read is in flight at a time.
- R11: Each accepted request gets exactly one single-cycle `rsp_valid` pulse. `req_ready` stays low from acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_gpa | input | 48 | Guest-physical address to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| root_ptr | input | 64 | Packed root pointer (type, levels−1, A/D enable, reserved, top frame) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result pulse |
| rsp_status | output | 2 | 0 ok, 1 violation, 2 configuration error |
| rsp_level | output | 2 | Level of the last entry examined |
| rsp_hpa | output | 48 | Host-physical address (0 unless ok) |
| rsp_memtype | output | 3 | Memory-type field of the root pointer |

## Verification
The result pulse of one walk and the arrival of the next request can fall in the same cycle. The bench provokes this by raising `req_valid` for the next translation in the very cycle where it observes `rsp_valid`. It then judges that the block ignores the request until it has returned to idle: `req_ready` must be low during the pulse, and no read may appear before the new expected address list is armed. In the same way, a stalled memory request and a final-entry decision are exercised one after the other, with random back-pressure on `mem_req_ready` and random response latency.

// File: rtl/s2w_pkg.sv
`timescale 1ns/1ps
package s2w_pkg;
  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_VIOL = 2'd1,
    ST_CFG  = 2'd2
  } stat_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/s2w_root_decode.sv
`timescale 1ns/1ps
module s2w_root_decode #(
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 36,
  parameter int LEVELS  = 4
) (
  input  logic [63:0]        ptr,
  output logic [FRAME_W-1:0] base,
  output logic [2:0]         memtype,
  output logic               cfg_ok
);
  localparam logic [2:0] WALK_CODE = 3'(LEVELS - 1);

  logic unused_ptr;
  assign unused_ptr = ^{ptr[63:OFF_W+FRAME_W], ptr[6]};

  assign base    = ptr[OFF_W +: FRAME_W];
  assign memtype = ptr[2:0];
  assign cfg_ok  = (ptr[5:3] == WALK_CODE) && (ptr[11:7] == 5'd0);
endmodule

// File: rtl/s2w_perm_check.sv
`timescale 1ns/1ps
module s2w_perm_check
  import s2w_pkg::*;
(
  input  logic [2:0] perm,
  input  acc_e       acc,
  output logic       grant
);
  logic present;
  assign present = |perm;

  always_comb begin
    unique case (acc)
      ACC_RD:  grant = present & perm[0];
      ACC_WR:  grant = present & perm[1];
      ACC_EX:  grant = present & perm[2];
      default: grant = 1'b0;
    endcase
  end
endmodule

// File: rtl/s2w_walker.sv
`timescale 1ns/1ps
module s2w_walker
  import s2w_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int GPA_W  = LEVELS * IDX_W + OFF_W,
  parameter int LVL_W  = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [GPA_W-1:0] req_gpa,
  input  logic [1:0]       req_acc,
  input  logic [63:0]      root_ptr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [GPA_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [LVL_W-1:0] rsp_level,
  output logic [GPA_W-1:0] rsp_hpa,
  output logic [2:0]       rsp_memtype
);
  localparam int FRAME_W = GPA_W - OFF_W;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // root pointer decode
  logic [FRAME_W-1:0] root_base;
  logic [2:0]         root_mt;
  logic               root_ok;
  s2w_root_decode #(.OFF_W(OFF_W), .FRAME_W(FRAME_W), .LEVELS(LEVELS)) u_root (
    .ptr(root_ptr), .base(root_base), .memtype(root_mt), .cfg_ok(root_ok)
  );

  // state
  walk_st_e           state_q, state_d;
  logic [GPA_W-1:0]   gpa_q;
  acc_e               acc_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] frame_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [2:0]         mt_q;
  stat_e              stat_q;

  // per-level index slices
  logic [IDX_W-1:0] idx_arr [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = gpa_q[GPA_W-1-g*IDX_W -: IDX_W];
  end
  logic [IDX_W-1:0] idx_sel;
  assign idx_sel = idx_arr[lvl_q];

  // entry interpretation
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_grant;
  logic               unused_ent;
  assign ent_frame  = mem_rsp_data[OFF_W +: FRAME_W];
  assign unused_ent = ^{mem_rsp_data[63:GPA_W], mem_rsp_data[OFF_W-1:3]};

  s2w_perm_check u_perm (
    .perm(mem_rsp_data[2:0]), .acc(acc_q), .grant(ent_grant)
  );

  // next-state logic with explicit enables
  logic cap_en, adv_en, ok_en, viol_en;
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    adv_en  = 1'b0;
    ok_en   = 1'b0;
    viol_en = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        cap_en  = 1'b1;
        state_d = root_ok ? S_ISSUE : S_DONE;
      end
      S_ISSUE: if (mem_req_ready) state_d = S_WAIT;
      S_WAIT: if (mem_rsp_valid) begin
        if (!ent_grant) begin
          viol_en = 1'b1;
          state_d = S_DONE;
        end else if (lvl_q == LAST_LVL) begin
          ok_en   = 1'b1;
          state_d = S_DONE;
        end else begin
          adv_en  = 1'b1;
          state_d = S_ISSUE;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      gpa_q   <= '0;
      acc_q   <= ACC_RD;
      base_q  <= '0;
      frame_q <= '0;
      lvl_q   <= '0;
      mt_q    <= '0;
      stat_q  <= ST_OK;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        gpa_q   <= req_gpa;
        acc_q   <= acc_e'(req_acc);
        base_q  <= root_base;
        frame_q <= '0;
        lvl_q   <= '0;
        mt_q    <= root_mt;
        stat_q  <= root_ok ? ST_OK : ST_CFG;
      end
      if (adv_en) begin
        base_q <= ent_frame;
        lvl_q  <= lvl_q + 1'b1;
      end
      if (ok_en) begin
        frame_q <= ent_frame;
        stat_q  <= ST_OK;
      end
      if (viol_en) begin
        frame_q <= '0;
        stat_q  <= ST_VIOL;
      end
    end
  end

  // outputs
  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_req_addr  = {base_q, {OFF_W{1'b0}}} | GPA_W'({idx_sel, 3'b000});
  assign rsp_valid     = (state_q == S_DONE);
  assign rsp_status    = stat_q;
  assign rsp_level     = lvl_q;
  assign rsp_hpa       = (stat_q == ST_OK) ? {frame_q, gpa_q[OFF_W-1:0]} : '0;
  assign rsp_memtype   = mt_q;
endmodule

// File: rtl/s2w_walker_chk.sv
`timescale 1ns/1ps
module s2w_walker_chk #(
  parameter int GPA_W  = 48,
  parameter int LVL_W  = 2,
  parameter int LEVELS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [GPA_W-1:0] mem_req_addr,
  input logic             rsp_valid,
  input logic [1:0]       rsp_status,
  input logic [LVL_W-1:0] rsp_level
);
  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid && !req_ready);

  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R11
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R8
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'd3);

  // R5
  ok_at_last_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 2'd0 |-> rsp_level == LVL_W'(LEVELS - 1));
endmodule

bind s2w_walker s2w_walker_chk #(.GPA_W(GPA_W), .LVL_W(LVL_W), .LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .rsp_level(rsp_level)
);

// File: tb/s2w_walker_tb.sv
`timescale 1ns/1ps
module s2w_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_gpa;
  logic [1:0]  req_acc;
  logic [63:0] root_ptr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [1:0]  rsp_level;
  logic [47:0] rsp_hpa;
  logic [2:0]  rsp_memtype;

  always #5 clk = ~clk;

  s2w_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_gpa(req_gpa), .req_acc(req_acc), .root_ptr(root_ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_level(rsp_level), .rsp_hpa(rsp_hpa), .rsp_memtype(rsp_memtype)
  );

  int checks = 0;
  int fails  = 0;
  bit stall_on = 1'b0;

  logic [63:0] tmem [logic [47:0]];
  logic [47:0] exp_addr [$];
  logic [1:0]  exp_stat;
  logic [1:0]  exp_lvl;
  logic [47:0] exp_hpa;
  logic [2:0]  exp_mt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkptr(input logic [35:0] frame, input logic [2:0] wl,
                                        input logic [4:0] rsv, input logic ad,
                                        input logic [2:0] mt);
    return {16'h0, frame, rsv, ad, wl, mt};
  endfunction

  // lay down a four-entry path for gpa
  task automatic map_path(input logic [63:0] ptr, input logic [47:0] gpa,
                          input logic [2:0] p0, input logic [2:0] p1,
                          input logic [2:0] p2, input logic [2:0] p3,
                          input logic [35:0] leaf);
    logic [2:0]  pm [4];
    logic [35:0] base;
    pm = '{p0, p1, p2, p3};
    base = ptr[47:12];
    for (int l = 0; l < 4; l++) begin
      logic [8:0]  idx;
      logic [35:0] nxt;
      logic [47:0] a;
      idx = gpa[47-9*l -: 9];
      a = {base, 12'h000} + 48'(idx) * 48'd8;
      nxt = (l == 3) ? leaf : (36'(l + 1) * 36'h1000 + 36'(idx) + 36'(gpa[7:0]) * 36'h10);
      tmem[a] = {16'h0, nxt, 9'h000, pm[l]};
      base = nxt;
    end
  endtask

  // behavioural reference: expected reads and result
  task automatic ref_walk(input logic [47:0] gpa, input logic [1:0] acc, input logic [63:0] ptr);
    logic [35:0] base;
    exp_mt = ptr[2:0];
    exp_stat = 2'd0; exp_lvl = 2'd0; exp_hpa = '0;
    if (ptr[5:3] != 3'd3 || ptr[11:7] != 5'd0) begin
      exp_stat = 2'd2;
      return;
    end
    base = ptr[47:12];
    for (int l = 0; l < 4; l++) begin
      logic [47:0] a;
      logic [63:0] e;
      bit ok;
      a = {base, 12'h000} + 48'(gpa[47-9*l -: 9]) * 48'd8;
      exp_addr.push_back(a);
      e = tmem.exists(a) ? tmem[a] : 64'h0;
      ok = (e[2:0] != 3'b000) && (acc != 2'd3) && e[acc];
      if (!ok) begin
        exp_stat = 2'd1; exp_lvl = 2'(l);
        return;
      end
      if (l == 3) begin
        exp_lvl = 2'd3;
        exp_hpa = {e[47:12], gpa[11:0]};
      end else begin
        base = e[47:12];
      end
    end
  endtask

  // request one translation; returns in the cycle the result is seen
  task automatic run(input logic [47:0] gpa, input logic [1:0] acc,
                     input logic [63:0] ptr, input string rtag);
    int wait_cyc;
    bit busy_ok;
    ref_walk(gpa, acc, ptr);
    req_gpa = gpa; req_acc = acc; root_ptr = ptr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_cyc = 0;
    busy_ok = 1'b1;
    while (!rsp_valid && wait_cyc < 200) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      wait_cyc++;
    end
    chk(busy_ok && !req_ready, "R11", "ready during walk/response", 64'(req_ready), 64'd0);
    chk(rsp_valid, "R11", "response pulse", 64'(rsp_valid), 64'd1);
    chk(rsp_status == exp_stat, rtag, "status", 64'(rsp_status), 64'(exp_stat));
    chk(rsp_level == exp_lvl, rtag, "level", 64'(rsp_level), 64'(exp_lvl));
    chk(rsp_hpa == exp_hpa, rtag, "hpa", 64'(rsp_hpa), 64'(exp_hpa));
    chk(rsp_memtype == exp_mt, "R9", "memtype", 64'(rsp_memtype), 64'(exp_mt));
    chk(exp_addr.size() == 0, "R3", "reads left unissued", 64'(exp_addr.size()), 64'd0);
    exp_addr.delete();
  endtask

  // memory responder with back-pressure and latency; checks every read
  initial begin
    logic [47:0] a;
    logic [47:0] held;
    bit pend_hold;
    pend_hold = 1'b0;
    held = '0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (pend_hold) begin
        // R10 request stays put while not accepted
        chk(mem_req_valid && mem_req_addr == held, "R10", "held request",
            64'(mem_req_addr), 64'(held));
        pend_hold = 1'b0;
      end
      mem_req_ready = stall_on ? 1'($urandom_range(0, 1)) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        a = mem_req_addr;
        if (exp_addr.size() == 0) chk(1'b0, "R8", "unexpected read", 64'(a), 64'd0);
        else begin
          logic [47:0] e;
          e = exp_addr.pop_front();
          chk(a == e, "R3", "entry address", 64'(a), 64'(e));
        end
        repeat (1 + $urandom_range(0, 2)) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = tmem.exists(a) ? tmem[a] : 64'h0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_req_ready = 1'b0;
        if (mem_req_valid) begin
          held = mem_req_addr;
          pend_hold = 1'b1;
        end
      end else if (mem_req_valid) begin
        held = mem_req_addr;
        pend_hold = 1'b1;
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R11 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] p_wb, p_uc, p_alt;
    bit idle_ok;
    rst_n = 1'b0; req_valid = 1'b0; req_gpa = '0; req_acc = '0; root_ptr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and idle with no request
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1", "reset outputs",
        {61'h0, req_ready, mem_req_valid, rsp_valid}, 64'h4);
    idle_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req_valid || rsp_valid || !req_ready) idle_ok = 1'b0;
    end
    chk(idle_ok, "R1", "idle activity", 64'(idle_ok), 64'd1);

    p_wb  = mkptr(36'h0_0040_0, 3'd3, 5'd0, 1'b0, 3'd6);
    p_uc  = mkptr(36'h0_0077_0, 3'd3, 5'd0, 1'b1, 3'd0);
    p_alt = mkptr(36'h0_0990_0, 3'd3, 5'd0, 1'b0, 3'd6);

    // R2 R4 R5: full read walk, all rights
    map_path(p_wb, 48'h1234_5678_9ABC, 3'b111, 3'b111, 3'b111, 3'b111, 36'h9_8765_4321);
    run(48'h1234_5678_9ABC, 2'd0, p_wb, "R5");
    // R9 write walk under uncached pointer, A/D enabled
    map_path(p_uc, 48'hFFFF_FFFF_F123, 3'b011, 3'b011, 3'b011, 3'b011, 36'h0_0000_0ABC);
    run(48'hFFFF_FFFF_F123, 2'd1, p_uc, "R5");
    // R6 execute refused at the final level
    map_path(p_wb, 48'h0000_0040_3007, 3'b111, 3'b111, 3'b111, 3'b011, 36'h1_1111_1111);
    run(48'h0000_0040_3007, 2'd2, p_wb, "R6");
    // R6 write refused at level 1
    map_path(p_wb, 48'h8001_0020_0FFF, 3'b111, 3'b101, 3'b111, 3'b111, 36'h2_2222_2222);
    run(48'h8001_0020_0FFF, 2'd1, p_wb, "R6");
    // R7 absent entry at level 2
    map_path(p_wb, 48'h7F00_00C0_1000, 3'b111, 3'b111, 3'b000, 3'b111, 36'h3_3333_3333);
    run(48'h7F00_00C0_1000, 2'd0, p_wb, "R7");
    // R7 nothing mapped under a fresh root: stops at level 0
    run(48'h0123_4567_8000, 2'd0, p_alt, "R7");
    // R8 bad walk-length code, then reserved bit set
    run(48'h1234_5678_9ABC, 2'd0, mkptr(36'h0_0040_0, 3'd2, 5'd0, 1'b0, 3'd6), "R8");
    run(48'h1234_5678_9ABC, 2'd0, mkptr(36'h0_0040_0, 3'd3, 5'h04, 1'b0, 3'd0), "R8");
    // R4 R10 repeat walks under random back-pressure
    stall_on = 1'b1;
    for (int k = 0; k < 6; k++) begin
      logic [47:0] g;
      g = {12'(k * 37 + 5), 12'(k * 411 + 3), 12'(k * 9 + 1), 12'(k * 123)};
      map_path(p_wb, g, 3'b111, 3'b111, 3'b111, 3'(3 + k % 5), 36'(k * 1000 + 7));
      run(g, 2'(k % 3), p_wb, "R6");
    end
    stall_on = 1'b0;
    // R1 idle again after the last response
    idle_ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req_valid || rsp_valid) idle_ok = 1'b0;
    end
    chk(idle_ok, "R1", "idle after walks", 64'(idle_ok), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule